// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects a set of interrupt sources and tells the core when to divert to an interrupt vector. Each source has three bits: a pending flag, an enable and a priority. A control word sets the operating mode and two global enable bits.

In the reset-default compatibility mode there is a single level. Bit 7 of the control word gates every source, and bit 6 also gates the peripheral group. Every request uses vector 0x000008. In priority mode, bit 7 enables the high level and bit 6 enables the low level. High requests vector to 0x000008 and low requests vector to 0x000018.

When the core takes a request it pulses `ack_i`. The block then clears the global enable of the level taken and records the level in its active state. A `ret_i` strobe at the end of a handler restores the enable and unwinds the active state by one level. Software finds the sources behind a request by polling `flags_o`.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the flags, enables, priority bits, control bits (mode, bit 7, bit 6) and active state are all zero, and `req_o` is low.
- R2: A source flag is set in the cycle after its `event_i` bit is high, whatever the enables are. It stays set until software writes it to zero through select 0. An event arriving in the same cycle as a clearing write wins.
- R3: Writes use `wr_sel_i` 0 for flags, 1 for enables, 2 for priority bits and 3 for the control word. In the control word, bit 0 is the mode, bit 7 is the global or high enable, and bit 6 is the peripheral or low enable. In compatibility mode (bit 0 = 0), a request needs flag, enable and bit 7, and also bit 6 for sources at index `CORE_SRC` and above. The vector is then 0x000008 with `lvl_hi_o`=1, and the priority bits are ignored.
- R4: In priority mode, a source with its priority bit set requests when its flag, its enable and bit 7 are set. The vector is 0x000008 with `lvl_hi_o`=1.
- R5: In priority mode, a source with its priority bit clear needs its flag, its enable, bit 6 and bit 7. The vector is 0x000018 with `lvl_hi_o`=0.
- R6: When both levels are pending and permitted, the high request is presented.
- R7: When `ack_i` is high while `req_o` is high, the enable of the presented level is cleared: bit 7 for a high or compatibility request, bit 6 for a low request. `active_o` records the level taken, encoded as 0 none, 1 low, 2 high, 3 high nested over low.
- R8: A high request may be raised while a low handler is active. No request is raised while a high handler is active, even if software sets the enables again.
- R9: On `ret_i`, bit 7 is set if it is clear; otherwise bit 6 is set. `active_o` unwinds one level: 3 becomes 1, and 2 or 1 becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | N_SRC | Per-source event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 flags, 1 enables, 2 priority, 3 control |
| wr_data_i | input | N_SRC | Write data |
| ack_i | input | 1 | Core takes the presented request |
| ret_i | input | 1 | Return-from-interrupt strobe |
| req_o | output | 1 | Vector request |
| vec_o | output | VEC_W | Vector address, valid with req_o |
| lvl_hi_o | output | 1 | Level of the presented request (1 = high) |
| flags_o | output | N_SRC | Pending flags for polling |
| gie_hi_o | output | 1 | Control bit 7 |
| gie_lo_o | output | 1 | Control bit 6 |
| active_o | output | 2 | Active handler level |

## Verification
A core source and a peripheral source are first raised in compatibility mode. The peripheral source is tried with bit 6 both clear and set, which shows the group gate apart from the global gate, and a zero priority bit still gives vector 0x000008. In priority mode, one high and one low source are pending together. The bench toggles bit 7 and bit 6 and clears the flags one at a time, which separates the level gating, the high-first choice and the low vector. A full low, then high-nested, then unwind sequence checks the preemption rule and the return order. Within that sequence, software re-enables both levels inside the high handler, which shows that the active record and not only the enables blocks further requests.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_LO   = 2'd1,
    ACT_HI   = 2'd2,
    ACT_NEST = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_CTL  = 2'd3
  } sel_e;

  localparam int CTL_MODE = 0;
  localparam int CTL_LO   = 6;
  localparam int CTL_HI   = 7;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] event_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [N_SRC-1:0] wr_data_i,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] prio_o
);
  import irq_pkg::*;

  logic wr_flag, wr_en, wr_prio;
  assign wr_flag = wr_en_i && (wr_sel_i == SEL_FLAG);
  assign wr_en   = wr_en_i && (wr_sel_i == SEL_EN);
  assign wr_prio = wr_en_i && (wr_sel_i == SEL_PRIO);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flags_o[i] <= 1'b0;
        en_o[i]    <= 1'b0;
        prio_o[i]  <= 1'b0;
      end else begin
        // event beats a same-cycle software clear
        flags_o[i] <= (wr_flag ? wr_data_i[i] : flags_o[i]) | event_i[i];
        if (wr_en)   en_o[i]   <= wr_data_i[i];
        if (wr_prio) prio_o[i] <= wr_data_i[i];
      end
    end

    assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_i[i] |=> flags_o[i]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int              N_SRC    = 8,
  parameter int              CORE_SRC = 2,
  parameter int              VEC_W    = 24,
  parameter logic [VEC_W-1:0] HI_VEC  = 'h08,
  parameter logic [VEC_W-1:0] LO_VEC  = 'h18
) (
  input  logic [N_SRC-1:0] flags_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             mode_i,
  input  logic             gie_hi_i,
  input  logic             gie_lo_i,
  input  logic [1:0]       act_i,
  output logic             req_o,
  output logic             lvl_hi_o,
  output logic [VEC_W-1:0] vec_o
);
  import irq_pkg::*;

  localparam logic [N_SRC-1:0] CORE_MASK = {N_SRC{1'b1}} >> (N_SRC - CORE_SRC);

  logic [N_SRC-1:0] pend;
  logic hi_free, lo_free, cmp_req, pri_hi, pri_lo;

  assign pend    = flags_i & en_i;
  assign hi_free = (act_i != ACT_HI) && (act_i != ACT_NEST);
  assign lo_free = (act_i == ACT_NONE);

  assign cmp_req = gie_hi_i && hi_free &&
                   ((|(pend & CORE_MASK)) || (gie_lo_i && |(pend & ~CORE_MASK)));
  assign pri_hi  = gie_hi_i && hi_free && |(pend & prio_i);
  // clearing the high enable masks the low level too
  assign pri_lo  = gie_hi_i && gie_lo_i && lo_free && |(pend & ~prio_i);

  always_comb begin
    if (mode_i) begin
      req_o    = pri_hi || pri_lo;
      lvl_hi_o = pri_hi;
    end else begin
      req_o    = cmp_req;
      lvl_hi_o = 1'b1;
    end
    vec_o = lvl_hi_o ? HI_VEC : LO_VEC;
  end
endmodule

// File: rtl/irq_level_fsm.sv
module irq_level_fsm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic [2:0] ctl_data_i,  // {hi, lo, mode}
  input  logic       ack_i,
  input  logic       ret_i,
  input  logic       req_i,
  input  logic       lvl_hi_i,
  output logic       mode_o,
  output logic       gie_hi_o,
  output logic       gie_lo_o,
  output logic [1:0] act_o
);
  import irq_pkg::*;

  act_e act_q, act_n;
  logic mode_n, hi_n, lo_n, take;

  assign take  = ack_i && req_i;
  assign act_o = act_q;

  always_comb begin
    mode_n = mode_o;
    hi_n   = gie_hi_o;
    lo_n   = gie_lo_o;
    act_n  = act_q;
    if (ctl_wr_i) begin
      mode_n = ctl_data_i[0];
      lo_n   = ctl_data_i[1];
      hi_n   = ctl_data_i[2];
    end
    if (take) begin
      if (lvl_hi_i) begin
        hi_n  = 1'b0;
        act_n = (act_q == ACT_LO) ? ACT_NEST : ACT_HI;
      end else begin
        lo_n  = 1'b0;
        act_n = ACT_LO;
      end
    end else if (ret_i) begin
      if (!gie_hi_o) hi_n = 1'b1;
      else           lo_n = 1'b1;
      act_n = (act_q == ACT_NEST) ? ACT_LO : ACT_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= 1'b0;
      gie_hi_o <= 1'b0;
      gie_lo_o <= 1'b0;
      act_q    <= ACT_NONE;
    end else begin
      mode_o   <= mode_n;
      gie_hi_o <= hi_n;
      gie_lo_o <= lo_n;
      act_q    <= act_n;
    end
  end

  assert_ack_hi_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_i && lvl_hi_i) |=> !gie_hi_o);
  assert_ack_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && req_i && !lvl_hi_i) |=> !gie_lo_o);
  assert_ret_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !take && !ctl_wr_i && !gie_hi_o) |=> gie_hi_o);
  assert_no_req_in_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == ACT_HI || act_q == ACT_NEST) |-> !req_i);
  assert_compat_one_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && req_i) |-> lvl_hi_i);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int               N_SRC    = 8,   // at least 8: control bits 6 and 7
  parameter int               CORE_SRC = 2,
  parameter int               VEC_W    = 24,
  parameter logic [VEC_W-1:0] HI_VEC   = 'h08,
  parameter logic [VEC_W-1:0] LO_VEC   = 'h18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] event_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic             ret_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             lvl_hi_o,
  output logic [N_SRC-1:0] flags_o,
  output logic             gie_hi_o,
  output logic             gie_lo_o,
  output logic [1:0]       active_o
);
  import irq_pkg::*;

  logic [N_SRC-1:0] en, prio;
  logic             mode, ctl_wr;

  assign ctl_wr = wr_en_i && (wr_sel_i == SEL_CTL);

  irq_src_regs #(.N_SRC(N_SRC)) i_regs (
    .clk_i, .rst_ni, .event_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .flags_o, .en_o(en), .prio_o(prio)
  );

  irq_arbiter #(
    .N_SRC(N_SRC), .CORE_SRC(CORE_SRC), .VEC_W(VEC_W),
    .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)
  ) i_arb (
    .flags_i(flags_o), .en_i(en), .prio_i(prio), .mode_i(mode),
    .gie_hi_i(gie_hi_o), .gie_lo_i(gie_lo_o), .act_i(active_o),
    .req_o, .lvl_hi_o, .vec_o
  );

  irq_level_fsm i_fsm (
    .clk_i, .rst_ni,
    .ctl_wr_i(ctl_wr),
    .ctl_data_i({wr_data_i[CTL_HI], wr_data_i[CTL_LO], wr_data_i[CTL_MODE]}),
    .ack_i, .ret_i, .req_i(req_o), .lvl_hi_i(lvl_hi_o),
    .mode_o(mode), .gie_hi_o, .gie_lo_o, .act_o(active_o)
  );
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ev = '0;
  logic        we = 1'b0;
  logic [1:0]  sel = '0;
  logic [7:0]  wd = '0;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        req, lvl, gh, gl;
  logic [23:0] vec;
  logic [7:0]  fl;
  logic [1:0]  act;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .event_i(ev), .wr_en_i(we), .wr_sel_i(sel),
    .wr_data_i(wd), .ack_i(ack), .ret_i(ret), .req_o(req), .vec_o(vec),
    .lvl_hi_o(lvl), .flags_o(fl), .gie_hi_o(gh), .gie_lo_o(gl), .active_o(act)
  );

  typedef struct {
    logic        req;
    logic [23:0] vec;
    logic        lvl;
    logic        gh;
    logic        gl;
    logic [1:0]  act;
    logic [7:0]  fl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (req !== e.req || gh !== e.gh || gl !== e.gl || act !== e.act || fl !== e.fl ||
            (e.req && (vec !== e.vec || lvl !== e.lvl))) begin
          n_fail++;
          $display("FAIL %s: got req=%0b vec=%h lvl=%0b gh=%0b gl=%0b act=%0d fl=%h exp req=%0b vec=%h lvl=%0b gh=%0b gl=%0b act=%0d fl=%h",
                   e.tag, req, vec, lvl, gh, gl, act, fl,
                   e.req, e.vec, e.lvl, e.gh, e.gl, e.act, e.fl);
        end
      end
    end
  end

  task automatic cyc(input logic [7:0] e_ev, input logic e_we, input logic [1:0] e_sel,
                     input logic [7:0] e_wd, input logic e_ack, input logic e_ret,
                     input logic x_req, input logic [23:0] x_vec, input logic x_lvl,
                     input logic x_gh, input logic x_gl, input logic [1:0] x_act,
                     input logic [7:0] x_fl, input string tag);
    exp_t e;
    @(negedge clk);
    ev = e_ev; we = e_we; sel = e_sel; wd = e_wd; ack = e_ack; ret = e_ret;
    e.req = x_req; e.vec = x_vec; e.lvl = x_lvl; e.gh = x_gh; e.gl = x_gl;
    e.act = x_act; e.fl = x_fl; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic run();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // compatibility mode
    cyc(8'h00, 0, 2'd0, 8'h00, 0, 0, 0, 24'h08, 1, 0, 0, 2'd0, 8'h00, "R1 reset state");
    cyc(8'h01, 0, 2'd0, 8'h00, 0, 0, 0, 24'h08, 1, 0, 0, 2'd0, 8'h01, "R2 flag set with enables off");
    cyc(8'h00, 1, 2'd1, 8'h01, 0, 0, 0, 24'h08, 1, 0, 0, 2'd0, 8'h01, "R3 no request without bit7");
    cyc(8'h00, 1, 2'd3, 8'h80, 0, 0, 1, 24'h08, 1, 1, 0, 2'd0, 8'h01, "R3 core source request");
    cyc(8'h08, 1, 2'd0, 8'h00, 0, 0, 0, 24'h08, 1, 1, 0, 2'd0, 8'h08, "R2 event wins over clear");
    cyc(8'h00, 1, 2'd1, 8'h08, 0, 0, 0, 24'h08, 1, 1, 0, 2'd0, 8'h08, "R3 peripheral needs bit6");
    cyc(8'h00, 1, 2'd3, 8'hC0, 0, 0, 1, 24'h08, 1, 1, 1, 2'd0, 8'h08, "R3 peripheral request, prio ignored");
    cyc(8'h00, 0, 2'd0, 8'h00, 1, 0, 0, 24'h08, 1, 0, 1, 2'd2, 8'h08, "R7 compat ack clears bit7");
    cyc(8'h00, 0, 2'd0, 8'h00, 0, 1, 1, 24'h08, 1, 1, 1, 2'd0, 8'h08, "R9 compat return");
    cyc(8'h00, 1, 2'd0, 8'h00, 0, 0, 0, 24'h08, 1, 1, 1, 2'd0, 8'h00, "R2 software clear");
    // priority mode
    cyc(8'h00, 1, 2'd3, 8'h41, 0, 0, 0, 24'h08, 1, 0, 1, 2'd0, 8'h00, "R3 control write");
    cyc(8'h00, 1, 2'd2, 8'h02, 0, 0, 0, 24'h08, 1, 0, 1, 2'd0, 8'h00, "R4 prio write");
    cyc(8'h00, 1, 2'd1, 8'h06, 0, 0, 0, 24'h08, 1, 0, 1, 2'd0, 8'h00, "R4 enable write");
    cyc(8'h06, 0, 2'd0, 8'h00, 0, 0, 0, 24'h08, 1, 0, 1, 2'd0, 8'h06, "R5 low masked by bit7 clear");
    cyc(8'h00, 1, 2'd3, 8'h81, 0, 0, 1, 24'h08, 1, 1, 0, 2'd0, 8'h06, "R4 high request");
    cyc(8'h00, 1, 2'd3, 8'hC1, 0, 0, 1, 24'h08, 1, 1, 1, 2'd0, 8'h06, "R6 high wins");
    cyc(8'h00, 1, 2'd0, 8'h04, 0, 0, 1, 24'h18, 0, 1, 1, 2'd0, 8'h04, "R5 low request vector");
    cyc(8'h00, 0, 2'd0, 8'h00, 1, 0, 0, 24'h08, 1, 1, 0, 2'd1, 8'h04, "R7 low ack clears bit6");
    cyc(8'h02, 0, 2'd0, 8'h00, 0, 0, 1, 24'h08, 1, 1, 0, 2'd1, 8'h06, "R8 high preempts low");
    cyc(8'h00, 0, 2'd0, 8'h00, 1, 0, 0, 24'h08, 1, 0, 0, 2'd3, 8'h06, "R7 nested ack");
    cyc(8'h00, 1, 2'd3, 8'hC1, 0, 0, 0, 24'h08, 1, 1, 1, 2'd3, 8'h06, "R8 blocked in high handler");
    cyc(8'h00, 1, 2'd3, 8'h01, 0, 0, 0, 24'h08, 1, 0, 0, 2'd3, 8'h06, "R8 restore enables");
    cyc(8'h00, 1, 2'd0, 8'h04, 0, 0, 0, 24'h08, 1, 0, 0, 2'd3, 8'h04, "R2 clear high flag");
    cyc(8'h00, 0, 2'd0, 8'h00, 0, 1, 0, 24'h08, 1, 1, 0, 2'd1, 8'h04, "R9 return sets bit7 first");
    cyc(8'h00, 0, 2'd0, 8'h00, 0, 1, 1, 24'h18, 0, 1, 1, 2'd0, 8'h04, "R9 return sets bit6");
    @(negedge clk);
    ev = '0; we = 1'b0; ack = 1'b0; ret = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run();
      begin
        repeat (5000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule